// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Bank

This block carries out already-decoded potentiometer commands. It keeps one wiper counter and a small bank of data registers. It moves values between them and answers reads. It also nudges the wiper one position at a time when the serial front end sends step pulses. The wiper value drives a one-hot selection across all tap switches of the resistor string. Position 0 is the low end and the all-ones position is the high end.

A command is presented for one cycle with `cmd_valid` high. It carries an opcode, a data register index and write data. Step pulses come in on a separate pair of pins. The block has no ready signal on the command side, so it accepts one command in every cycle. Read results go out as a stream with a valid flag and no ready. `rd_valid` is high for exactly one cycle, and the consumer must take `rd_data` in that cycle because the block cannot be back-pressured. `rd_data` then holds its value until the next read.

Top module: `pot_cmd_exec`

## Requirements
- R1: After reset, the wiper counter and all four data registers are 0, `tap_sel` equals 1 (only bit 0 set), and `rd_valid` is 0.
- R2: The write-wiper opcode (`cmd_op`=1) loads `cmd_wdata` into the wiper counter at the clock edge that samples the command.
- R3: The write-data opcode (`cmd_op`=3) stores `cmd_wdata` in the data register chosen by `cmd_idx`. The read-data opcode (`cmd_op`=2) returns that register on `rd_data`.
- R4: The read-wiper opcode (`cmd_op`=0) returns the wiper counter on `rd_data`.
- R5: The load opcode (`cmd_op`=4) copies the data register chosen by `cmd_idx` into the wiper counter.
- R6: The store opcode (`cmd_op`=5) copies the wiper counter into the data register chosen by `cmd_idx`.
- R7: When `cmd_valid` is low, a `step_pulse` with `step_up`=1 raises the wiper counter by one. At 63 it stays at 63.
- R8: When `cmd_valid` is low, a `step_pulse` with `step_up`=0 lowers the wiper counter by one. At 0 it stays at 0.
- R9: `tap_sel` always has exactly one bit set, and that bit is the one whose index equals the wiper counter.
- R10: If `cmd_valid` and `step_pulse` are high in the same cycle, the command takes effect and the step is dropped.
- R11: Opcodes 6 and 7 change neither the wiper counter nor any data register, and they do not raise `rd_valid`.
- R12: `rd_valid` is high for exactly the one cycle after a read command (opcode 0 or 2) is sampled. `rd_data` shows the register value from before any update in that command's cycle, and it holds that value afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 rd wiper, 1 wr wiper, 2 rd data, 3 wr data, 4 load, 5 store, 6/7 none |
| cmd_idx | input | 2 | Data register index |
| cmd_wdata | input | 6 | Write value for opcodes 1 and 3 |
| step_pulse | input | 1 | One-cycle step request |
| step_up | input | 1 | Step direction, 1 = toward high end |
| rd_valid | output | 1 | Read result valid, one cycle |
| rd_data | output | 6 | Read result |
| tap_sel | output | 64 | One-hot tap switch select |

## Verification
The bench drives stepping across both ends of the range. A counter that wraps would show tap 0 after 63, or tap 63 after 0, where the bench expects the end value to stay put. It sends a command and a step in the same cycle. A design that merged the two, or let the step win, would leave the wiper one position off the written value. Load and store are run with several indices, so a swapped or ignored index shows up as the wrong value on readback. The unused opcodes are followed by full readback, which exposes any stray write and any spurious read pulse.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_DATA  = 3'd2,
    OP_WR_DATA  = 3'd3,
    OP_LOAD     = 3'd4,
    OP_STORE    = 3'd5,
    OP_RSVD6    = 3'd6,
    OP_RSVD7    = 3'd7
  } pot_op_e;

  function automatic logic op_is_read(input pot_op_e op);
    return (op == OP_RD_WIPER) || (op == OP_RD_DATA);
  endfunction
endpackage

// File: rtl/pot_regfile.sv
module pot_regfile
  import pot_pkg::*;
#(
  parameter int W      = 6,
  parameter int N_DATA = 4,
  localparam int IDXW  = $clog2(N_DATA)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  pot_op_e         cmd_op,
  input  logic [IDXW-1:0] cmd_idx,
  input  logic [W-1:0]    cmd_wdata,
  input  logic [W-1:0]    wiper,
  output logic [W-1:0]    rd_val
);
  logic [W-1:0] data_q [N_DATA];
  logic         wr_any;
  logic [W-1:0] wr_val;

  // Write source: direct write data or the wiper (store).
  always_comb begin
    wr_any = cmd_valid && (cmd_op == OP_WR_DATA || cmd_op == OP_STORE);
    wr_val = (cmd_op == OP_STORE) ? wiper : cmd_wdata;
  end

  for (genvar i = 0; i < N_DATA; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        data_q[i] <= '0;
      else if (wr_any && cmd_idx == IDXW'(i))
        data_q[i] <= wr_val;
    end
  end

  assign rd_val = data_q[cmd_idx];
endmodule

// File: rtl/pot_wiper.sv
module pot_wiper
  import pot_pkg::*;
#(
  parameter int W      = 6,
  localparam int MAXV  = (1 << W) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  pot_op_e      cmd_op,
  input  logic [W-1:0] cmd_wdata,
  input  logic [W-1:0] load_val,
  input  logic         step_pulse,
  input  logic         step_up,
  output logic [W-1:0] wiper_q
);
  logic [W-1:0] wiper_d;
  logic         at_top;
  logic         at_bot;

  assign at_top = (wiper_q == W'(MAXV));
  assign at_bot = (wiper_q == '0);

  // Commands outrank steps; steps saturate at both ends.
  always_comb begin
    wiper_d = wiper_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WR_WIPER: wiper_d = cmd_wdata;
        OP_LOAD:     wiper_d = load_val;
        default:     wiper_d = wiper_q;
      endcase
    end else if (step_pulse) begin
      if (step_up && !at_top)
        wiper_d = wiper_q + 1'b1;
      else if (!step_up && !at_bot)
        wiper_d = wiper_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper_q <= '0;
    else        wiper_q <= wiper_d;
  end
endmodule

// File: rtl/pot_tap_decode.sv
module pot_tap_decode #(
  parameter int W     = 6,
  localparam int TAPS = 1 << W
) (
  input  logic [W-1:0]    wiper,
  output logic [TAPS-1:0] tap_sel
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = (wiper == W'(i));
  end
endmodule

// File: rtl/pot_cmd_exec.sv
module pot_cmd_exec
  import pot_pkg::*;
#(
  parameter int W      = 6,
  parameter int N_DATA = 4,
  localparam int IDXW  = $clog2(N_DATA),
  localparam int TAPS  = 1 << W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [IDXW-1:0] cmd_idx,
  input  logic [W-1:0]    cmd_wdata,
  input  logic            step_pulse,
  input  logic            step_up,
  output logic            rd_valid,
  output logic [W-1:0]    rd_data,
  output logic [TAPS-1:0] tap_sel
);
  pot_op_e      op;
  logic [W-1:0] wiper_q;
  logic [W-1:0] data_rd;

  assign op = pot_op_e'(cmd_op);

  pot_regfile #(.W(W), .N_DATA(N_DATA)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (op),
    .cmd_idx   (cmd_idx),
    .cmd_wdata (cmd_wdata),
    .wiper     (wiper_q),
    .rd_val    (data_rd)
  );

  pot_wiper #(.W(W)) u_wiper (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (op),
    .cmd_wdata  (cmd_wdata),
    .load_val   (data_rd),
    .step_pulse (step_pulse),
    .step_up    (step_up),
    .wiper_q    (wiper_q)
  );

  pot_tap_decode #(.W(W)) u_tap (
    .wiper   (wiper_q),
    .tap_sel (tap_sel)
  );

  // Read capture uses pre-update register state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cmd_valid && op_is_read(op);
      if (cmd_valid && op == OP_RD_WIPER)
        rd_data <= wiper_q;
      else if (cmd_valid && op == OP_RD_DATA)
        rd_data <= data_rd;
    end
  end
endmodule

// File: rtl/pot_cmd_exec_chk.sv
module pot_cmd_exec_chk #(
  parameter int W     = 6,
  localparam int TAPS = 1 << W,
  localparam int MAXV = TAPS - 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic [W-1:0]    cmd_wdata,
  input logic            step_pulse,
  input logic            step_up,
  input logic            rd_valid,
  input logic [TAPS-1:0] tap_sel,
  input logic [W-1:0]    wiper
);
  logic is_rd;
  assign is_rd = cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd2);

  assert_tap_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  assert_tap_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[wiper] == 1'b1);

  assert_wr_wiper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> wiper == $past(cmd_wdata));

  assert_step_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && step_pulse && step_up && wiper != W'(MAXV))
      |=> wiper == $past(wiper) + 1'b1);

  assert_step_up_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && step_pulse && step_up && wiper == W'(MAXV)) |=> wiper == W'(MAXV));

  assert_step_dn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && step_pulse && !step_up && wiper != '0)
      |=> wiper == $past(wiper) - 1'b1);

  assert_step_dn_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && step_pulse && !step_up && wiper == '0) |=> wiper == '0);

  assert_cmd_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 3'd1 && cmd_op != 3'd4) |=> $stable(wiper));

  assert_rsvd_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[2:1] == 2'b11) |=> !rd_valid);

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid);

  assert_rd_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rd_valid);
endmodule

bind pot_cmd_exec pot_cmd_exec_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_wdata  (cmd_wdata),
  .step_pulse (step_pulse),
  .step_up    (step_up),
  .rd_valid   (rd_valid),
  .tap_sel    (tap_sel),
  .wiper      (wiper_q)
);

// File: tb/test_pot_cmd_exec.sv
module test_pot_cmd_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_idx = 2'd0;
  logic [5:0]  cmd_wdata = 6'd0;
  logic        step_pulse = 1'b0;
  logic        step_up = 1'b0;
  logic        rd_valid;
  logic [5:0]  rd_data;
  logic [63:0] tap_sel;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pot_cmd_exec i_pot_cmd_exec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .step_pulse(step_pulse),
    .step_up(step_up), .rd_valid(rd_valid), .rd_data(rd_data), .tap_sel(tap_sel)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive one cycle of stimulus; returns at the negedge after the sampling edge.
  task automatic cyc(input logic v, input logic [2:0] op, input logic [1:0] idx,
                     input logic [5:0] wd, input logic sp, input logic up);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_idx = idx; cmd_wdata = wd;
    step_pulse = sp; step_up = up;
    @(negedge clk);
    cmd_valid = 1'b0; step_pulse = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] op, input logic [1:0] idx,
                    input logic [5:0] exp);
    cyc(1'b1, op, idx, 6'd0, 1'b0, 1'b0);
    check({req, " rd_valid"}, {63'd0, rd_valid}, 64'd1);
    check({req, " rd_data"}, {58'd0, rd_data}, {58'd0, exp});
  endtask

  task automatic tap_is(input string req, input int pos);
    check(req, tap_sel, 64'd1 << pos);
  endtask

  task automatic t_reset;
    check("R1 tap", tap_sel, 64'd1);
    check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    rd("R1 wiper", 3'd0, 2'd0, 6'd0);
    for (int i = 0; i < 4; i++) rd("R1 data", 3'd2, 2'(i), 6'd0);
  endtask

  task automatic t_write_wiper;
    cyc(1'b1, 3'd1, 2'd0, 6'd37, 1'b0, 1'b0);
    tap_is("R2 R9 write 37", 37);
    rd("R4 read wiper", 3'd0, 2'd0, 6'd37);
  endtask

  task automatic t_data_regs;
    for (int i = 0; i < 4; i++) cyc(1'b1, 3'd3, 2'(i), 6'(10 + 11 * i), 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) rd("R3 data readback", 3'd2, 2'(i), 6'(10 + 11 * i));
    tap_is("R3 wiper untouched", 37);
  endtask

  task automatic t_load;
    cyc(1'b1, 3'd3, 2'd2, 6'd50, 1'b0, 1'b0);
    cyc(1'b1, 3'd4, 2'd2, 6'd0, 1'b0, 1'b0);
    tap_is("R5 load idx2", 50);
    cyc(1'b1, 3'd4, 2'd3, 6'd0, 1'b0, 1'b0);
    tap_is("R5 load idx3", 43);
  endtask

  task automatic t_store;
    cyc(1'b1, 3'd1, 2'd0, 6'd13, 1'b0, 1'b0);
    cyc(1'b1, 3'd5, 2'd1, 6'd0, 1'b0, 1'b0);
    rd("R6 store idx1", 3'd2, 2'd1, 6'd13);
    rd("R6 idx0 kept", 3'd2, 2'd0, 6'd10);
  endtask

  task automatic t_step_up;
    cyc(1'b1, 3'd1, 2'd0, 6'd61, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 3'd0, 2'd0, 6'd0, 1'b1, 1'b1);
      tap_is("R7 step up", (61 + i + 1 > 63) ? 63 : 61 + i + 1);
    end
  endtask

  task automatic t_step_down;
    cyc(1'b1, 3'd1, 2'd0, 6'd2, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 3'd0, 2'd0, 6'd0, 1'b1, 1'b0);
      tap_is("R8 step down", (2 - i - 1 < 0) ? 0 : 2 - i - 1);
    end
  endtask

  task automatic t_priority;
    cyc(1'b1, 3'd1, 2'd0, 6'd20, 1'b0, 1'b0);
    cyc(1'b1, 3'd1, 2'd0, 6'd30, 1'b1, 1'b1);
    tap_is("R10 write beats step", 30);
    cyc(1'b1, 3'd0, 2'd0, 6'd0, 1'b1, 1'b0);
    check("R10 read beats step rd", {58'd0, rd_data}, 64'd30);
    tap_is("R10 read beats step tap", 30);
  endtask

  task automatic t_reserved;
    cyc(1'b1, 3'd6, 2'd1, 6'd55, 1'b0, 1'b0);
    check("R11 op6 rd_valid", {63'd0, rd_valid}, 64'd0);
    cyc(1'b1, 3'd7, 2'd2, 6'd55, 1'b0, 1'b0);
    check("R11 op7 rd_valid", {63'd0, rd_valid}, 64'd0);
    tap_is("R11 wiper kept", 30);
    rd("R11 data1 kept", 3'd2, 2'd1, 6'd13);
    rd("R11 data2 kept", 3'd2, 2'd2, 6'd50);
  endtask

  task automatic t_rd_hold;
    rd("R12 read", 3'd0, 2'd0, 6'd30);
    @(negedge clk);
    check("R12 pulse ends", {63'd0, rd_valid}, 64'd0);
    check("R12 data holds", {58'd0, rd_data}, 64'd30);
    cyc(1'b1, 3'd1, 2'd0, 6'd5, 1'b0, 1'b0);
    check("R12 no pulse on write", {63'd0, rd_valid}, 64'd0);
    check("R12 data still held", {58'd0, rd_data}, 64'd30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_wiper();
    t_data_regs();
    t_load();
    t_store();
    t_step_up();
    t_step_down();
    t_priority();
    t_reserved();
    t_rd_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule